// File: doc/BRIEF.md
# Keyed Software Reset Controller

This block gives software a single memory-mapped control word that it can write to ask for a reset. The write is accepted only when the upper halfword carries a fixed unlock pattern. Two request bits are honoured. The first asks for a reset of the processor core alone. The second asks for a system-wide reset. A built-in generator waits a configurable number of cycles before it asserts the system reset, then holds that reset for a configurable minimum length.

There are three active-low reset outputs: one for the core domain, one for the system domain and one for the debug domain. Software can never assert the debug reset. Only the external power-on reset input drives it. All outputs come straight from flops and are released in step with the clock.

Top module: `swrst_ctrl`

## Requirements
- R1: A write changes nothing unless `bus_wdata[31:16]` equals 0x05FA. A write with any other upper halfword causes no reset of any kind. This includes the pattern placed in the lower half and the byte-swapped value 0xFA05.
- R2: Writes take effect only when `bus_addr` equals `REG_OFFSET` (default 0xED0C). A write to any other address causes no reset.
- R3: A keyed write with bit 0 set and bit 2 clear drives `core_rst_n` low for exactly `CORE_PULSE` cycles, starting at the second clock edge after the write edge. `sys_rst_n` and `dbg_rst_n` stay high. The other data bits have no function.
- R4: A keyed write with bit 2 set leaves every output high for `SYS_DELAY+1` edges. It then drives `sys_rst_n` low from the (`SYS_DELAY`+2)-th edge after the write. During that delay the core keeps running, and keyed writes are still accepted.
- R5: The system reset stays low for exactly `SYS_HOLD` cycles. `core_rst_n` is low in every cycle in which `sys_rst_n` is low.
- R6: A keyed write with both bit 0 and bit 2 set performs only the system reset. No separate core pulse comes before it.
- R7: Reading at `REG_OFFSET` returns 0xFA050000, even while a request is pending. Any other address reads 0.
- R8: While `rst_n` is low, all three outputs are low from the next edge onward. A request that is pending or delayed when `rst_n` is asserted is discarded.
- R9: Writes are ignored while a core or system reset pulse is being applied. A second system request during the delay neither extends nor repeats the system reset.
- R10: `dbg_rst_n` is never driven low by any software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External power-on reset, active low, sampled synchronously |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | 32 | Write data, unlock key in the upper halfword |
| bus_rdata | output | 32 | Read data for the addressed word |
| core_rst_n | output | 1 | Core-domain reset, active low |
| sys_rst_n | output | 1 | System-domain reset, active low |
| dbg_rst_n | output | 1 | Debug-domain reset, active low |

## Verification
A wrong key or address decode shows up as a reset pulse that should not happen, or one that is missing. The bench sees this within `SYS_DELAY+2` cycles of the write. A counter that is off by one moves the start edge of a pulse or changes its length, and both are measured cycle by cycle. If a request flag does not clear, or a busy window is not honoured, a second pulse appears after the first. The observation window is long enough to contain that second pulse. If the power-on clear of the delay counter is missing, a system reset appears after `rst_n` is released.

// File: rtl/swrst_pkg.sv
// Shared constants and types for the keyed software reset controller.
package swrst_pkg;
    localparam logic [15:0] UNLOCK_KEY = 16'h05FA;  // required upper halfword on writes
    localparam logic [15:0] READ_TAG   = 16'hFA05;  // upper halfword returned on reads
    localparam int          CORE_BIT   = 0;         // core-only request bit
    localparam int          SYS_BIT    = 2;         // system request bit

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_WAIT = 2'd1,
        GEN_HOLD = 2'd2
    } gen_state_e;
endpackage

// File: rtl/swrst_keyreg.sv
// Keyed control word: decodes the address and unlock key and latches the
// core and system request flags. Reads return the fixed tag with the
// request bits reading zero.
// Assumes one-cycle write strobes. The flags clear when the matching reset
// is applied, because the word lives inside the domain it resets.
module swrst_keyreg
    import swrst_pkg::*;
#(
    parameter int               ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'hED0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              core_active,
    input  logic              sys_active,
    output logic              core_req,
    output logic              sys_req,
    output logic [31:0]       bus_rdata
);
    logic hit;
    logic key_ok;
    logic accept;

    // Address and key decode for the current bus cycle.
    assign hit    = (bus_addr == REG_OFFSET);
    assign key_ok = (bus_wdata[31:16] == UNLOCK_KEY);
    assign accept = bus_wr && hit && key_ok && !core_active && !sys_active;

    // Read path: fixed tag, request bits always read as zero.
    assign bus_rdata = hit ? {READ_TAG, 16'h0000} : 32'h0000_0000;

    // Request flags: set by accepted writes, cleared once the reset is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_req <= 1'b0;
            sys_req  <= 1'b0;
        end else if (sys_active) begin
            core_req <= 1'b0;
            sys_req  <= 1'b0;
        end else begin
            if (core_active) begin
                core_req <= 1'b0;
            end
            if (accept) begin
                if (bus_wdata[SYS_BIT]) begin
                    sys_req <= 1'b1;
                end else if (bus_wdata[CORE_BIT]) begin
                    core_req <= 1'b1;
                end
            end
        end
    end

    // R1: a write with a bad key leaves idle request flags idle.
    p_bad_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !key_ok && !core_req && !sys_req) |=> (!core_req && !sys_req));

    // R3: spare data bits alone never raise a request.
    p_spare_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && key_ok && !bus_wdata[SYS_BIT] && !bus_wdata[CORE_BIT]
         && ({bus_wdata[15:3], bus_wdata[1]} != '0) && !core_req && !sys_req)
        |=> (!core_req && !sys_req));

    // R9: an applied system reset drops every pending request.
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_active |=> (!core_req && !sys_req));
endmodule

// File: rtl/swrst_core_pulse.sv
// Core reset pulse: on a request it asserts its output for PULSE cycles.
// Requests that arrive while the pulse is running are ignored.
// Assumes PULSE >= 1.
module swrst_core_pulse #(
    parameter int PULSE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active
);
    localparam int              CW       = $clog2(PULSE + 1);
    localparam logic [CW-1:0]   PULSE_M1 = CW'(PULSE - 1);
    localparam logic [CW-1:0]   PULSE_V  = CW'(PULSE);

    logic [CW-1:0] cnt;

    // Pulse timer: load on a request, count down, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!active && req) begin
            active <= 1'b1;
            cnt    <= PULSE_M1;
        end else if (active) begin
            if (cnt == '0) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R3: the remaining count stays within the configured pulse length.
    p_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < PULSE_V));
endmodule

// File: rtl/swrst_sys_gen.sv
// System reset generator: after a request it waits DELAY cycles, then
// holds its reset for HOLD cycles before returning to idle.
// Assumes DELAY >= 1 and HOLD >= 1. The request stays high until the
// hold phase starts.
module swrst_sys_gen
    import swrst_pkg::*;
#(
    parameter int DELAY = 8,
    parameter int HOLD  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active
);
    localparam int            MAXV     = (DELAY > HOLD) ? DELAY : HOLD;
    localparam int            CW       = $clog2(MAXV + 1);
    localparam logic [CW-1:0] DELAY_M1 = CW'(DELAY - 1);
    localparam logic [CW-1:0] HOLD_M1  = CW'(HOLD - 1);

    gen_state_e    state;
    logic [CW-1:0] cnt;

    // Delay and hold sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GEN_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                GEN_IDLE: begin
                    if (req) begin
                        state <= GEN_WAIT;
                        cnt   <= DELAY_M1;
                    end
                end
                GEN_WAIT: begin
                    if (cnt == '0) begin
                        state <= GEN_HOLD;
                        cnt   <= HOLD_M1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                GEN_HOLD: begin
                    if (cnt == '0) begin
                        state <= GEN_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= GEN_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Reset is applied only during the hold phase.
    assign active = (state == GEN_HOLD);

    // R4: a request seen while idle always starts the delay window.
    p_req_to_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GEN_IDLE && req) |=> (state == GEN_WAIT));

    // R9: the hold phase never leads straight back into another delay.
    p_hold_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GEN_HOLD) |=> (state != GEN_WAIT));
endmodule

// File: rtl/swrst_ctrl.sv
// Top level: keyed control word, core pulse timer, system reset generator
// and registered active-low reset outputs. The debug reset follows only
// the external reset input.
// Assumes rst_n is already synchronous to clk.
module swrst_ctrl #(
    parameter int               ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'hED0C,
    parameter int               CORE_PULSE = 3,
    parameter int               SYS_DELAY  = 8,
    parameter int               SYS_HOLD   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              core_rst_n,
    output logic              sys_rst_n,
    output logic              dbg_rst_n
);
    logic core_req;
    logic sys_req;
    logic core_active;
    logic sys_active;

    swrst_keyreg #(
        .ADDR_W    (ADDR_W),
        .REG_OFFSET(REG_OFFSET)
    ) keyreg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .core_active(core_active),
        .sys_active (sys_active),
        .core_req   (core_req),
        .sys_req    (sys_req),
        .bus_rdata  (bus_rdata)
    );

    swrst_core_pulse #(
        .PULSE(CORE_PULSE)
    ) core_pulse_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (core_req),
        .active(core_active)
    );

    swrst_sys_gen #(
        .DELAY(SYS_DELAY),
        .HOLD (SYS_HOLD)
    ) sys_gen_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (sys_req),
        .active(sys_active)
    );

    // Output flops: glitch-free resets that deassert on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_rst_n <= 1'b0;
            sys_rst_n  <= 1'b0;
            dbg_rst_n  <= 1'b0;
        end else begin
            core_rst_n <= !(core_active || sys_active);
            sys_rst_n  <= !sys_active;
            dbg_rst_n  <= 1'b1;
        end
    end

    // R5: whenever the system domain is in reset, the core is too.
    p_core_covers_sys_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> !core_rst_n);

    // R10: with the external reset released, the debug reset goes and stays high.
    p_dbg_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> dbg_rst_n);
endmodule

// File: tb/swrst_ctrl_tb_top.sv
// Self-checking bench for swrst_ctrl: a vector table of writes, then
// directed tests for busy windows, overlap and power-on reset.
module swrst_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P   = 3;
    localparam int D   = 8;
    localparam int H   = 6;
    localparam int MON = 2 * D + H + 8;
    localparam logic [15:0] OFS = 16'hED0C;
    localparam int NV = 10;

    // Vector table: address, data, expected kind (0 none, 1 core, 2 system).
    localparam logic [15:0] V_ADDR [NV] = '{16'hED0C, 16'hED0C, 16'hED0C, 16'hED0C, 16'hED08,
                                           16'hED0C, 16'hED0C, 16'hED0C, 16'hEE0C, 16'hED0C};
    localparam logic [31:0] V_DATA [NV] = '{32'h05FA_0001, 32'h05FB_0001, 32'h05FA_0004,
                                           32'h15FA_0004, 32'h05FA_0001, 32'h05FA_0005,
                                           32'h0000_05FD, 32'h05FA_0002, 32'h05FA_0004,
                                           32'hFA05_0004};
    localparam int          V_KIND [NV] = '{1, 0, 2, 0, 0, 2, 0, 0, 0, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        core_rst_n, sys_rst_n, dbg_rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    swrst_ctrl #(
        .ADDR_W(16), .REG_OFFSET(OFS), .CORE_PULSE(P), .SYS_DELAY(D), .SYS_HOLD(H)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_rst_n(core_rst_n),
        .sys_rst_n(sys_rst_n), .dbg_rst_n(dbg_rst_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    // One write, an optional second write at sample k2, then MON samples.
    task automatic run_seq(input logic [15:0] a, input logic [31:0] d, input int k2,
                           input logic [15:0] a2, input logic [31:0] d2,
                           output int cf, output int cl, output int sf, output int sl,
                           output int dl, output logic [31:0] rd1);
        cf = 0; cl = 0; sf = 0; sl = 0; dl = 0; rd1 = 32'h0;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        for (int k = 1; k <= MON; k++) begin
            @(negedge clk);
            if (!core_rst_n) begin cl++; if (cf == 0) cf = k; end
            if (!sys_rst_n)  begin sl++; if (sf == 0) sf = k; end
            if (!dbg_rst_n)  dl++;
            if (k == 1) rd1 = bus_rdata;
            if (k == k2) begin
                bus_wr = 1'b1; bus_addr = a2; bus_wdata = d2;
            end else begin
                bus_wr = 1'b0; bus_addr = a;
            end
        end
    endtask

    task automatic expect_kind(input string req, input int kind, input int cf, input int cl,
                               input int sf, input int sl, input int dl);
        int ecf, ecl, esf, esl;
        ecf = (kind == 1) ? 2 : (kind == 2) ? D + 2 : 0;
        ecl = (kind == 1) ? P : (kind == 2) ? H : 0;
        esf = (kind == 2) ? D + 2 : 0;
        esl = (kind == 2) ? H : 0;
        chk(req, "core first low", cf, ecf);
        chk(req, "core low cycles", cl, ecl);
        chk(req, "sys first low", sf, esf);
        chk(req, "sys low cycles", sl, esl);
        chk("R10", "dbg low cycles", dl, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int cf, cl, sf, sl, dl;
        logic [31:0] rd;

        // R8: reset state, all outputs asserted.
        repeat (3) @(negedge clk);
        chk("R8", "core in reset", int'(core_rst_n), 0);
        chk("R8", "sys in reset", int'(sys_rst_n), 0);
        chk("R8", "dbg in reset", int'(dbg_rst_n), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "core released", int'(core_rst_n), 1);
        chk("R8", "sys released", int'(sys_rst_n), 1);
        chk("R10", "dbg released", int'(dbg_rst_n), 1);
        bus_addr = OFS;
        #1 chk("R7", "read at offset", int'(bus_rdata), int'(32'hFA05_0000));
        bus_addr = 16'h1234;
        #1 chk("R7", "read elsewhere", int'(bus_rdata), 0);

        // Vector table walk (R1, R2, R3, R4, R5, R6, R7).
        for (int i = 0; i < NV; i++) begin
            run_seq(V_ADDR[i], V_DATA[i], -1, 16'h0, 32'h0, cf, cl, sf, sl, dl, rd);
            expect_kind($sformatf("R1/R2/R3/R4/R5/R6 vec%0d", i), V_KIND[i], cf, cl, sf, sl, dl);
            chk("R7", $sformatf("read while pending vec%0d", i), int'(rd),
                (V_ADDR[i] == OFS) ? int'(32'hFA05_0000) : 0);
        end

        // R9: a second system request during the delay adds nothing.
        run_seq(OFS, 32'h05FA_0004, 3, OFS, 32'h05FA_0004, cf, cl, sf, sl, dl, rd);
        expect_kind("R9 repeat in delay", 2, cf, cl, sf, sl, dl);

        // R9: a system write during the hold phase is ignored.
        run_seq(OFS, 32'h05FA_0004, D + 3, OFS, 32'h05FA_0004, cf, cl, sf, sl, dl, rd);
        expect_kind("R9 write in hold", 2, cf, cl, sf, sl, dl);

        // R9: a system write during a core pulse is ignored.
        run_seq(OFS, 32'h05FA_0001, 1, OFS, 32'h05FA_0004, cf, cl, sf, sl, dl, rd);
        expect_kind("R9 write in core pulse", 1, cf, cl, sf, sl, dl);

        // R4: the core still runs during the delay and accepts a core request.
        run_seq(OFS, 32'h05FA_0004, 2, OFS, 32'h05FA_0001, cf, cl, sf, sl, dl, rd);
        chk("R4", "core pulse in delay first", cf, 5);
        chk("R4", "core low total", cl, P + H);
        chk("R4", "sys first low", sf, D + 2);
        chk("R5", "sys low cycles", sl, H);

        // R8: power-on reset in the middle of a delay discards the request.
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = OFS; bus_wdata = 32'h05FA_0004;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "core during por", int'(core_rst_n), 0);
        chk("R8", "sys during por", int'(sys_rst_n), 0);
        chk("R8", "dbg during por", int'(dbg_rst_n), 0);
        rst_n = 1'b1;
        sl = 0; cl = 0;
        for (int k = 1; k <= MON; k++) begin
            @(negedge clk);
            if (!sys_rst_n) sl++;
            if (!core_rst_n) cl++;
        end
        chk("R8", "sys low after por", sl, 0);
        chk("R8", "core low after por", cl, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule